// File: doc/BRIEF.md
# Lamp Inverter Fault Supervisor

This block supervises a multi-lamp backlight inverter. It takes synchronous one-bit comparator flags from the lamp sense path, a strobe for each switching cycle and an ignition-detected indication. From these it decides when to cut the four gate-drive outputs, and it keeps that decision until software or reset clears it. It also follows the inverter's two operating phases. Striking is the ignition phase after enable. Normal mode starts once the lamps are lit.

Each fault has its own qualification rule:
- An arc trips at once, in either phase.
- A short lamp and an open lamp during normal mode must each persist for a time window.
- An open lamp during striking is allowed a long ignition window, after which the supervisor gives up.
- An over-voltage must last for a set number of switching pulses.

A fault that does not persist does not build up time. All windows are parameters in clock cycles. The first fault to trip is recorded as a code.

Top module: `lamp_fault_sup`

## Requirements
- R1: While `en_i` is low, `shutdown_o`=0, `fault_o`=0, `normal_o`=0 and `gate_en_o`=4'b0000. After reset with `en_i` high, the block starts in striking mode with `gate_en_o`=4'b1111.
- R2: `arc_i` sampled high at a clock edge while running sets `shutdown_o`=1 and `fault_o`=1 after that edge, in either mode.
- R3: In normal mode, `short_i` held high for SHORT_CYC consecutive edges trips shutdown with `fault_o`=2 after the SHORT_CYC-th edge, and not before.
- R4: `short_i` has no effect in striking mode.
- R5: In striking mode, `open_strike_i` held high for STRIKE_CYC consecutive edges trips shutdown with `fault_o`=5. It is ignored in normal mode.
- R6: In normal mode, `open_run_i` held high for OPEN_CYC consecutive edges trips shutdown with `fault_o`=3. It is ignored in striking mode.
- R7: In normal mode, while `ov_i` stays high, the OVP_PULSES-th `pulse_i` strobe trips shutdown with `fault_o`=4 after the edge that samples it. A low `ov_i` resets the pulse count. Over-voltage is ignored in striking mode.
- R8: If a fault flag drops for one edge before its window completes, that window's count restarts from zero.
- R9: `ignite_i` sampled high while running sets `normal_o`=1 after that edge and clears the striking window.
- R10: Shutdown is latched. While it is set, `gate_en_o`=4'b0000. Only reset or a low `en_i` clears it.
- R11: `fault_o` holds the code of the first fault to trip and does not change while shutdown holds. If several faults trip on the same edge, the lowest code wins: 1 arc, 2 short, 3 open in normal mode, 4 over-voltage, 5 striking timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low clears all state |
| arc_i | input | 1 | Maximum sense voltage above arc threshold |
| short_i | input | 1 | Minimum sense voltage below short threshold |
| open_strike_i | input | 1 | Minimum sense voltage below striking open threshold |
| open_run_i | input | 1 | Minimum sense voltage below normal-mode open threshold |
| ov_i | input | 1 | Over-voltage comparator flag |
| pulse_i | input | 1 | One-cycle strobe per switching cycle |
| ignite_i | input | 1 | Lamps ignited; enter normal mode |
| shutdown_o | output | 1 | Latched shutdown |
| gate_en_o | output | 4 | Enables for gate outputs A to D |
| fault_o | output | 3 | Code of the first fault |
| normal_o | output | 1 | High in normal mode, low in striking |

## Verification
A window count that fails to restart, or starts early, shows as `shutdown_o` rising one or more edges before or after the exact edge given by the window length. The bench therefore samples one cycle before each expected trip and again on it. A wrong mode bit shows as a masked fault tripping, or an enabled fault never tripping, within one window. A corrupted latch or code register shows as `gate_en_o` reopening, or `fault_o` changing, on the cycle after a later fault.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ARC    = 3'd1,
    FLT_SHORT  = 3'd2,
    FLT_OPEN   = 3'd3,
    FLT_OVP    = 3'd4,
    FLT_STRIKE = 3'd5
  } fault_e;
endpackage

// File: rtl/lfs_hold_timer.sv
module lfs_hold_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic expire_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!act_i)          cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = act_i && (cnt_q == LAST);

  p_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= LAST);
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) !act_i |=> cnt_q == '0);
endmodule

// File: rtl/lfs_pulse_count.sv
module lfs_pulse_count #(
  parameter int unsigned PULSES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic pulse_i,
  output logic expire_o
);
  localparam int unsigned W = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [W-1:0] LAST = W'(PULSES - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!act_i)                    cnt_q <= '0;
    else if (pulse_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = act_i && pulse_i && (cnt_q == LAST);

  p_ovp_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) !act_i |=> cnt_q == '0);
  p_ovp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i && !pulse_i |=> cnt_q == $past(cnt_q) || !$past(act_i));
endmodule

// File: rtl/lamp_fault_sup.sv
module lamp_fault_sup
  import lfs_pkg::*;
#(
  parameter int unsigned SHORT_CYC  = 50_000,
  parameter int unsigned OPEN_CYC   = 500_000,
  parameter int unsigned STRIKE_CYC = 80_000_000,
  parameter int unsigned OVP_PULSES = 32,
  parameter int unsigned N_GATES    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               arc_i,
  input  logic               short_i,
  input  logic               open_strike_i,
  input  logic               open_run_i,
  input  logic               ov_i,
  input  logic               pulse_i,
  input  logic               ignite_i,
  output logic               shutdown_o,
  output logic [N_GATES-1:0] gate_en_o,
  output logic [2:0]         fault_o,
  output logic               normal_o
);
  localparam int unsigned N_TMR = 3;
  localparam int unsigned LIM [N_TMR] = '{SHORT_CYC, OPEN_CYC, STRIKE_CYC};

  logic   sd_q, normal_q, run;
  fault_e code_q, code_n;
  logic [N_TMR-1:0] tmr_act, tmr_exp;
  logic   ovp_act, ovp_exp;

  assign run = en_i && !sd_q;

  // 0: short (normal), 1: open (normal), 2: open (striking, cleared on ignition)
  assign tmr_act[0] = run && normal_q && short_i;
  assign tmr_act[1] = run && normal_q && open_run_i;
  assign tmr_act[2] = run && !normal_q && !ignite_i && open_strike_i;
  assign ovp_act    = run && normal_q && ov_i;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    lfs_hold_timer #(.LIMIT(LIM[i])) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (tmr_act[i]),
      .expire_o (tmr_exp[i])
    );
  end

  lfs_pulse_count #(.PULSES(OVP_PULSES)) u_ovp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (ovp_act),
    .pulse_i  (pulse_i),
    .expire_o (ovp_exp)
  );

  always_comb begin
    code_n = FLT_NONE;
    if (run && arc_i)    code_n = FLT_ARC;
    else if (tmr_exp[0]) code_n = FLT_SHORT;
    else if (tmr_exp[1]) code_n = FLT_OPEN;
    else if (ovp_exp)    code_n = FLT_OVP;
    else if (tmr_exp[2]) code_n = FLT_STRIKE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_q     <= 1'b0;
      code_q   <= FLT_NONE;
      normal_q <= 1'b0;
    end else if (!en_i) begin
      sd_q     <= 1'b0;
      code_q   <= FLT_NONE;
      normal_q <= 1'b0;
    end else if (!sd_q) begin
      if (code_n != FLT_NONE) begin
        sd_q   <= 1'b1;
        code_q <= code_n;
      end
      if (ignite_i) normal_q <= 1'b1;
    end
  end

  assign shutdown_o = sd_q;
  assign fault_o    = code_q;
  assign normal_o   = normal_q;
  assign gate_en_o  = {N_GATES{run}};

  p_disable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !shutdown_o && fault_o == 3'd0 && !normal_o);
  p_arc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !shutdown_o && arc_i |=> shutdown_o && fault_o == 3'd1);
  p_short_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !normal_q |-> !tmr_exp[0]);
  p_ignite_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !shutdown_o && ignite_i |=> normal_o);
  p_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && shutdown_o |=> shutdown_o);
  p_code_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && shutdown_o |=> $stable(fault_o));
endmodule

// File: tb/tb_lamp_fault_sup.sv
module tb_lamp_fault_sup;
  localparam int unsigned SC = 8, OC = 12, STC = 20, NP = 5;

  logic clk = 0, rst_ni = 0, en_i = 0;
  logic arc_i = 0, short_i = 0, open_strike_i = 0, open_run_i = 0;
  logic ov_i = 0, pulse_i = 0, ignite_i = 0;
  logic shutdown_o, normal_o;
  logic [3:0] gate_en_o;
  logic [2:0] fault_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  lamp_fault_sup #(.SHORT_CYC(SC), .OPEN_CYC(OC), .STRIKE_CYC(STC), .OVP_PULSES(NP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .arc_i(arc_i), .short_i(short_i),
    .open_strike_i(open_strike_i), .open_run_i(open_run_i), .ov_i(ov_i),
    .pulse_i(pulse_i), .ignite_i(ignite_i), .shutdown_o(shutdown_o),
    .gate_en_o(gate_en_o), .fault_o(fault_o), .normal_o(normal_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    arc_i = 0; short_i = 0; open_strike_i = 0; open_run_i = 0;
    ov_i = 0; pulse_i = 0; ignite_i = 0;
  endtask

  // clear via enable, return in striking mode
  task automatic restart(input bit to_normal);
    quiet(); en_i = 0; cyc(1); en_i = 1; cyc(1);
    if (to_normal) begin ignite_i = 1; cyc(1); ignite_i = 0; end
  endtask

  task automatic t_reset();
    chk("R1 sd off", shutdown_o, 0); chk("R1 gates off", gate_en_o, 0);
    chk("R1 code", fault_o, 0);
    en_i = 1; cyc(1);
    chk("R1 gates on", gate_en_o, 4'hF); chk("R1 striking", normal_o, 0);
  endtask

  task automatic t_arc();
    restart(0);
    arc_i = 1; cyc(1);
    chk("R2 sd", shutdown_o, 1); chk("R2 code", fault_o, 1);
    chk("R10 gates", gate_en_o, 0);
    arc_i = 0; short_i = 1; cyc(5);
    chk("R10 latched", shutdown_o, 1); chk("R11 code held", fault_o, 1);
    short_i = 0; en_i = 0; cyc(1);
    chk("R1 cleared", shutdown_o, 0); chk("R1 code clr", fault_o, 0);
    chk("R1 gates off", gate_en_o, 0);
    en_i = 1; cyc(1);
    chk("R10 reopen", gate_en_o, 4'hF);
  endtask

  task automatic t_short();
    restart(0);
    short_i = 1; cyc(3 * SC);
    chk("R4 masked", shutdown_o, 0);
    short_i = 0; ignite_i = 1; cyc(1); ignite_i = 0;
    chk("R9 normal", normal_o, 1);
    short_i = 1; cyc(SC - 1); short_i = 0; cyc(1);
    short_i = 1; cyc(SC - 1);
    chk("R8 restart", shutdown_o, 0);
    cyc(1);
    chk("R3 sd", shutdown_o, 1); chk("R3 code", fault_o, 2);
  endtask

  task automatic t_open_run();
    restart(1);
    open_strike_i = 1; cyc(2 * STC);
    chk("R5 ignored normal", shutdown_o, 0);
    open_strike_i = 0; open_run_i = 1; cyc(OC - 1);
    chk("R6 early", shutdown_o, 0);
    cyc(1);
    chk("R6 sd", shutdown_o, 1); chk("R6 code", fault_o, 3);
    restart(0);
    open_run_i = 1; cyc(2 * OC);
    chk("R6 ignored striking", shutdown_o, 0);
  endtask

  task automatic t_strike();
    restart(0);
    open_strike_i = 1; cyc(STC - 5);
    ignite_i = 1; cyc(1); ignite_i = 0; cyc(2 * STC);
    chk("R9 strike timer cleared", shutdown_o, 0);
    restart(0);
    open_strike_i = 1; cyc(STC - 1);
    chk("R5 early", shutdown_o, 0);
    cyc(1);
    chk("R5 sd", shutdown_o, 1); chk("R5 code", fault_o, 5);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pulse_i = 1; cyc(1); pulse_i = 0; cyc(2);
    end
  endtask

  task automatic t_ovp();
    restart(0);
    ov_i = 1; pulses(3 * NP);
    chk("R7 ignored striking", shutdown_o, 0);
    restart(1);
    ov_i = 1; pulses(NP - 1);
    ov_i = 0; cyc(1); ov_i = 1;
    pulses(NP - 1);
    chk("R7 count reset", shutdown_o, 0);
    pulse_i = 1; cyc(1); pulse_i = 0;
    chk("R7 sd", shutdown_o, 1); chk("R7 code", fault_o, 4);
  endtask

  task automatic t_prio();
    restart(1);
    short_i = 1; cyc(SC - 1);
    arc_i = 1; cyc(1);
    chk("R11 arc wins", fault_o, 1);
    restart(1);
    short_i = 1; cyc(SC);
    chk("R3 sd", fault_o, 2);
    arc_i = 1; cyc(2);
    chk("R11 first kept", fault_o, 2);
    quiet();
  endtask

  initial begin
    cyc(2); rst_ni = 1; cyc(1);
    t_reset(); t_arc(); t_short(); t_open_run(); t_strike(); t_ovp(); t_prio();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule